// File: doc/BRIEF.md
# Key-Locked Configuration Port Controller

This block is the configuration front end of an I/O-mapped peripheral. It decodes two neighbouring byte addresses on a simple bus with address, write strobe, read strobe, write data and read data: a key/index port and, one address above it, a data port. After reset the block sits in a locked run state in which its registers cannot be reached. Writing an unlock key to the key/index port opens the configuration state. Writing a lock key closes it again.

While unlocked, a byte written to the key/index port selects a configuration register and the data port reads or writes that register. The registers fall into two kinds. Global registers hold a logical-device selector and two read-only identification bytes. Banked registers have a separate copy for each logical device, chosen by the selector. One logical device keeps a 16-bit base address in two of its banked registers, and the block drives that address on an output so that a companion decoder can place its own index/data pair there.

Top module: `cfgport_ctrl`

## Requirements
- R1: In the run state, writing 0x55 to the key/index port (address 0x002E) enters the configuration state. Any other byte written there in the run state is ignored.
- R2: In the configuration state, writing 0xAA to the key/index port returns the block to the run state.
- R3: In the run state, data-port (address 0x002F) writes change no register, and a read of either port returns 0xFF.
- R4: In the configuration state, writing any byte other than 0xAA to the key/index port loads the index register, including 0x55. A read of that port returns the current index.
- R5: In the configuration state, the data port reads and writes the register selected by the index. Index 0x07 is the logical-device selector, a read/write byte.
- R6: Index 0x20 always reads 0x6F and index 0x21 always reads 0x01. Writes to either are discarded.
- R7: Indexes 0x30 and 0x60 to 0x63 are banked: logical devices 0 to 8 each keep their own copy. A write under one selector value leaves every other device's copy unchanged.
- R8: The base_addr output is {device 8 index 0x60, device 8 index 0x61}. It shows a new value in the cycle after the data-port write.
- R9: After reset the block is in the run state with index 0 and selector 0. base_addr is 0x0480 (device 8 index 0x60 = 0x04, index 0x61 = 0x80), and every other banked register is 0x00.
- R10: Unimplemented indexes, and banked indexes while the selector is 9 or above, read 0x00 and ignore writes.
- R11: Read data is combinational and appears in the same cycle as the read strobe. It is 0x00 when no read is active or when the address is neither port.
- R12: If read and write strobes are high in the same cycle on the data port, the read returns the value before the write, and the write takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| base_addr | output | 16 | Base address held by logical device 8 |

## Verification
Two functions can meet in one cycle: a data-port read and a data-port write to the same register. The bench raises both strobes together on a register that holds a known value. It samples read data before the clock edge and expects the old value. It then reads the register on its own and expects the new value. Key traffic is also checked in the same way: after a register write, the lock key is written in the next cycle, and base_addr must keep the value just written while the data port goes back to returning 0xFF.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef enum logic {
    ST_RUN = 1'b0,
    ST_CFG = 1'b1
  } cfg_state_e;

  typedef struct packed {
    logic is_sel;
    logic is_id;
    logic is_rev;
    logic is_bank;
  } reg_kind_t;

endpackage

// File: rtl/cfgport_lock.sv
module cfgport_lock
  import cfgport_pkg::*;
#(
  parameter int          DW         = 8,
  parameter logic [DW-1:0] KEY_OPEN  = 8'h55,
  parameter logic [DW-1:0] KEY_CLOSE = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  output cfg_state_e    state,
  output logic [DW-1:0] index
);

  cfg_state_e    st_q, st_d;
  logic [DW-1:0] idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_RUN: begin
        if (key_data == KEY_OPEN) st_d = ST_CFG;
      end
      ST_CFG: begin
        if (key_data == KEY_CLOSE) st_d = ST_RUN;
        else                       idx_d = key_data;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      idx_q <= '0;
    end else if (key_wr) begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign state = st_q;
  assign index = idx_q;

endmodule

// File: rtl/cfgport_regdec.sv
module cfgport_regdec
  import cfgport_pkg::*;
#(
  parameter int            DW        = 8,
  parameter int            WIN_DEPTH = 4,
  parameter int            SLW       = 3,
  parameter logic [DW-1:0] IDX_SEL   = 8'h07,
  parameter logic [DW-1:0] IDX_ID    = 8'h20,
  parameter logic [DW-1:0] IDX_REV   = 8'h21,
  parameter logic [DW-1:0] IDX_ACT   = 8'h30,
  parameter logic [DW-1:0] IDX_WIN   = 8'h60
) (
  input  logic [DW-1:0]  index,
  output reg_kind_t      kind,
  output logic [SLW-1:0] slot
);

  logic [DW-1:0] win_off;
  logic          in_win;

  assign win_off = index - IDX_WIN;
  assign in_win  = (index >= IDX_WIN) && (win_off < DW'(WIN_DEPTH));

  always_comb begin
    kind         = '0;
    slot         = '0;
    kind.is_sel  = (index == IDX_SEL);
    kind.is_id   = (index == IDX_ID);
    kind.is_rev  = (index == IDX_REV);
    if (index == IDX_ACT) begin
      kind.is_bank = 1'b1;
      slot         = '0;
    end else if (in_win) begin
      kind.is_bank = 1'b1;
      slot         = SLW'(win_off + DW'(1));
    end
  end

endmodule

// File: rtl/cfgport_ldev_bank.sv
module cfgport_ldev_bank #(
  parameter int                 DW        = 8,
  parameter int                 NSLOT     = 5,
  parameter int                 SLW       = 3,
  parameter logic [DW*NSLOT-1:0] RST_IMAGE = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SLW-1:0]      wr_slot,
  input  logic [DW-1:0]       wr_data,
  output logic [DW*NSLOT-1:0] image
);

  logic [DW*NSLOT-1:0] img_q, img_d;

  always_comb begin
    img_d = img_q;
    for (int s = 0; s < NSLOT; s++) begin
      if (wr_slot == SLW'(s)) img_d[DW*s +: DW] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     img_q <= RST_IMAGE;
    else if (wr_en) img_q <= img_d;
  end

  assign image = img_q;

endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int              AW         = 16,
  parameter int              DW         = 8,
  parameter logic [AW-1:0]   KEY_PORT   = 16'h002E,
  parameter logic [DW-1:0]   KEY_OPEN   = 8'h55,
  parameter logic [DW-1:0]   KEY_CLOSE  = 8'hAA,
  parameter int              NUM_LDEV   = 9,
  parameter int              BASE_LDEV  = 8,
  parameter int              WIN_DEPTH  = 4,
  parameter logic [DW-1:0]   ID_VAL     = 8'h6F,
  parameter logic [DW-1:0]   REV_VAL    = 8'h01,
  parameter logic [2*DW-1:0] BASE_RST   = 16'h0480
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [2*DW-1:0] base_addr
);

  localparam int            NSLOT    = 1 + WIN_DEPTH;
  localparam int            SLW      = $clog2(NSLOT);
  localparam int            IMGW     = DW * NSLOT;
  localparam logic [AW-1:0] DAT_PORT = KEY_PORT + AW'(1);
  localparam logic [DW-1:0] IDX_ID   = 8'h20;
  localparam logic [IMGW-1:0] BASE_IMG =
    IMGW'({BASE_RST[DW-1:0], BASE_RST[2*DW-1:DW], {DW{1'b0}}});

  logic            at_key, at_dat;
  logic            key_wr, dat_wr;
  cfg_state_e      state;
  logic            cfg_mode;
  logic [DW-1:0]   cfg_index;
  reg_kind_t       kind;
  logic [SLW-1:0]  slot;
  logic [DW-1:0]   sel_q, sel_d;
  logic            sel_en;
  logic            sel_ok;
  logic [IMGW-1:0] bank_img [NUM_LDEV];
  logic [IMGW-1:0] cur_img;
  logic [DW-1:0]   reg_val;

  assign at_key   = (bus_addr == KEY_PORT);
  assign at_dat   = (bus_addr == DAT_PORT);
  assign key_wr   = bus_wr && at_key;
  assign cfg_mode = (state == ST_CFG);
  assign dat_wr   = bus_wr && at_dat && cfg_mode;

  cfgport_lock #(
    .DW        (DW),
    .KEY_OPEN  (KEY_OPEN),
    .KEY_CLOSE (KEY_CLOSE)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (bus_wdata),
    .state    (state),
    .index    (cfg_index)
  );

  cfgport_regdec #(
    .DW        (DW),
    .WIN_DEPTH (WIN_DEPTH),
    .SLW       (SLW),
    .IDX_ID    (IDX_ID)
  ) u_dec (
    .index (cfg_index),
    .kind  (kind),
    .slot  (slot)
  );

  // logical-device selector register
  assign sel_en = dat_wr && kind.is_sel;
  assign sel_d  = bus_wdata;
  assign sel_ok = (sel_q < DW'(NUM_LDEV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  for (genvar g = 0; g < NUM_LDEV; g++) begin : g_ldev
    localparam logic [IMGW-1:0] IMG = (g == BASE_LDEV) ? BASE_IMG : '0;
    logic wr_this;
    assign wr_this = dat_wr && kind.is_bank && (sel_q == DW'(g));
    cfgport_ldev_bank #(
      .DW        (DW),
      .NSLOT     (NSLOT),
      .SLW       (SLW),
      .RST_IMAGE (IMG)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_this),
      .wr_slot (slot),
      .wr_data (bus_wdata),
      .image   (bank_img[g])
    );
  end

  always_comb begin
    cur_img = '0;
    for (int g = 0; g < NUM_LDEV; g++) begin
      if (sel_q == DW'(g)) cur_img = bank_img[g];
    end
  end

  always_comb begin
    reg_val = '0;
    if (kind.is_sel) begin
      reg_val = sel_q;
    end else if (kind.is_id) begin
      reg_val = ID_VAL;
    end else if (kind.is_rev) begin
      reg_val = REV_VAL;
    end else if (kind.is_bank && sel_ok) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (slot == SLW'(s)) reg_val = cur_img[DW*s +: DW];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (at_key)      bus_rdata = cfg_mode ? cfg_index : {DW{1'b1}};
      else if (at_dat) bus_rdata = cfg_mode ? reg_val   : {DW{1'b1}};
    end
  end

  assign base_addr = {bank_img[BASE_LDEV][DW +: DW], bank_img[BASE_LDEV][2*DW +: DW]};

endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
  parameter int            AW        = 16,
  parameter int            DW        = 8,
  parameter logic [AW-1:0] KEY_PORT  = 16'h002E,
  parameter logic [DW-1:0] KEY_OPEN  = 8'h55,
  parameter logic [DW-1:0] KEY_CLOSE = 8'hAA,
  parameter logic [DW-1:0] ID_VAL    = 8'h6F
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [2*DW-1:0] base_addr,
  input logic            cfg_mode,
  input logic [DW-1:0]   cfg_index
);

  logic at_key, at_dat;
  assign at_key = (bus_addr == KEY_PORT);
  assign at_dat = (bus_addr == KEY_PORT + AW'(1));

  assert_unlock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && bus_wr && at_key && bus_wdata == KEY_OPEN) |=> cfg_mode);

  assert_relock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && bus_wr && at_key && bus_wdata == KEY_CLOSE) |=> !cfg_mode);

  assert_locked_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && bus_rd && (at_key || at_dat)) |-> (bus_rdata == {DW{1'b1}}));

  assert_index_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && bus_wr && at_key && bus_wdata != KEY_CLOSE) |=> (cfg_index == $past(bus_wdata)));

  assert_id_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && bus_rd && at_dat && cfg_index == 8'h20) |-> (bus_rdata == ID_VAL));

  assert_base_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(base_addr));

  assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !(at_key || at_dat)) |-> (bus_rdata == '0));

endmodule

bind cfgport_ctrl cfgport_checker #(
  .AW        (AW),
  .DW        (DW),
  .KEY_PORT  (KEY_PORT),
  .KEY_OPEN  (KEY_OPEN),
  .KEY_CLOSE (KEY_CLOSE),
  .ID_VAL    (ID_VAL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .base_addr (base_addr),
  .cfg_mode  (cfg_mode),
  .cfg_index (cfg_index)
);

// File: tb/cfgport_ctrl_bench.sv
module cfgport_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KP = 16'h002E;
  localparam logic [15:0] DP = 16'h002F;

  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [15:0] base_addr;

  int total = 0;
  int bad   = 0;

  cfgport_ctrl u_cfgport_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .base_addr (base_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
    bus_write(KP, idx);
    bus_write(DP, v);
  endtask

  task automatic get_reg(input logic [7:0] idx, output logic [7:0] v);
    bus_write(KP, idx);
    bus_read(DP, v);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    check("R9 base after reset", base_addr, 16'h0480);
    bus_read(KP, d); check("R3 key port locked read", d, 8'hFF);
    bus_read(DP, d); check("R3 data port locked read", d, 8'hFF);
  endtask

  task automatic t_locked_ignore();
    logic [7:0] d;
    bus_write(KP, 8'h12);
    bus_read(KP, d); check("R1 non-key byte ignored", d, 8'hFF);
    bus_write(DP, 8'h00);
    check("R3 locked data write", base_addr, 16'h0480);
  endtask

  task automatic t_unlock();
    logic [7:0] d;
    bus_write(KP, 8'h55);
    bus_read(KP, d); check("R1/R9 unlocked, index 0", d, 8'h00);
    get_reg(8'h07, d); check("R9 selector 0", d, 8'h00);
    bus_read(KP, d); check("R4 index readback", d, 8'h07);
    bus_write(KP, 8'h55);
    bus_read(KP, d); check("R4 0x55 loads index", d, 8'h55);
  endtask

  task automatic t_ids();
    logic [7:0] d;
    get_reg(8'h20, d); check("R6 id", d, 8'h6F);
    bus_write(DP, 8'h00);
    bus_read(DP, d); check("R6 id write discarded", d, 8'h6F);
    get_reg(8'h21, d); check("R6 rev", d, 8'h01);
    bus_write(DP, 8'hFF);
    bus_read(DP, d); check("R6 rev write discarded", d, 8'h01);
  endtask

  task automatic t_banks();
    logic [7:0] d;
    set_reg(8'h07, 8'h00); set_reg(8'h60, 8'hA5); set_reg(8'h30, 8'h01);
    set_reg(8'h07, 8'h03); set_reg(8'h60, 8'h3C);
    get_reg(8'h60, d); check("R7 dev3 0x60", d, 8'h3C);
    get_reg(8'h30, d); check("R7 dev3 0x30 untouched", d, 8'h00);
    set_reg(8'h07, 8'h00);
    get_reg(8'h60, d); check("R5/R7 dev0 0x60", d, 8'hA5);
    get_reg(8'h30, d); check("R7 dev0 0x30", d, 8'h01);
    get_reg(8'h63, d); check("R9 dev0 0x63 reset", d, 8'h00);
    set_reg(8'h07, 8'h08);
    get_reg(8'h07, d); check("R5 selector readback", d, 8'h08);
    get_reg(8'h60, d); check("R9 dev8 0x60", d, 8'h04);
    get_reg(8'h61, d); check("R9 dev8 0x61", d, 8'h80);
  endtask

  task automatic t_base_update();
    bus_write(KP, 8'h60);
    bus_write(DP, 8'h12);
    check("R8 base high byte next cycle", base_addr, 16'h1280);
    bus_write(KP, 8'h61);
    bus_write(DP, 8'h34);
    check("R8 base low byte next cycle", base_addr, 16'h1234);
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    get_reg(8'h25, d); check("R10 unimpl global", d, 8'h00);
    set_reg(8'h40, 8'hFF);
    get_reg(8'h40, d); check("R10 unimpl banked write ignored", d, 8'h00);
    set_reg(8'h07, 8'h0B);
    get_reg(8'h60, d); check("R10 bad selector read", d, 8'h00);
    set_reg(8'h60, 8'h99);
    check("R10 bad selector write ignored", base_addr, 16'h1234);
    set_reg(8'h07, 8'h08);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    set_reg(8'h07, 8'h00);
    set_reg(8'h61, 8'h77);
    @(negedge clk);
    bus_addr = DP; bus_wdata = 8'h99; bus_wr = 1'b1; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(posedge clk);
    #1 begin bus_wr = 1'b0; bus_rd = 1'b0; end
    check("R12 read returns old value", d, 8'h77);
    bus_read(DP, d); check("R12 write applied", d, 8'h99);
  endtask

  task automatic t_other_addr();
    logic [7:0] d;
    bus_read(16'h0480, d); check("R11 foreign address", d, 8'h00);
    @(negedge clk);
    bus_addr = DP; #2 check("R11 no strobe", bus_rdata, 8'h00);
  endtask

  task automatic t_lock_cycle();
    logic [7:0] d;
    set_reg(8'h07, 8'h08);
    set_reg(8'h61, 8'h56);
    bus_write(KP, 8'hAA);
    check("R8 base kept across lock", base_addr, 16'h1256);
    bus_read(DP, d); check("R2 locked again", d, 8'hFF);
    bus_write(DP, 8'h00);
    check("R3 locked write no effect", base_addr, 16'h1256);
    bus_write(KP, 8'h55);
    bus_read(KP, d); check("R2 index kept while locked", d, 8'h61);
    bus_read(DP, d); check("R3 register unchanged", d, 8'h56);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset_state();
    t_locked_ignore();
    t_unlock();
    t_ids();
    t_banks();
    t_base_update();
    t_unimpl();
    t_same_cycle();
    t_other_addr();
    t_lock_cycle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule